// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block raises interrupts from a wide GPIO bank using only eight interrupt groups. Each group watches one input pin. A 4-bit selector chooses which byte lane of which port the group listens to. The pin's position inside that byte is fixed by the group number, so group g can only ever see pins whose index is congruent to g modulo 8. Each group has a 3-bit trigger mode covering level-high, level-low, rising, falling and either-edge detection, plus a forced-active state. Each group also has an enable bit and a write-one acknowledge.

The selected pin passes through a two-flop synchroniser before detection. Edge modes latch a pending bit, and software must acknowledge it. Level modes report the synchronised pin state directly. One combined, registered interrupt line goes high while any enabled group is pending. Software reads the raw pending bits or the enabled pending bits over a simple synchronous register bus with a one-cycle read latency.

Top module: `gpio_group_irq`

## Requirements
- R1: After reset, the mode, selector and enable registers read zero, no group is pending and `irq_o` is low.
- R2: The mode register sits at offset 120, with group g's 3-bit code in bits [3g+2:3g]. The selector register sits at offset 124, with group g's 4-bit field in bits [4g+3:4g]. The enable register sits at offset 128, in bits [7:0]. Unused upper bits read zero.
- R3: With selector value s, group g watches flat pin index 32*(s/4) + 8*(s%4) + g, which equals 8*s + g. Here the flat index of bit b of port p is 32*p + b.
- R4: Mode 1 (level high) and mode 2 (level low) make pending equal to the synchronised pin level, or its inverse. Pending is not latched, and an acknowledge does not change it.
- R5: Mode 3 holds pending at 1. Modes 0 and 4 hold pending at 0.
- R6: Mode 5 (rising), mode 6 (falling) and mode 7 (either edge) set pending on the matching transition of the synchronised pin. Pending then stays set after the pin returns.
- R7: Writing offset 132 with bit g set clears group g's latched edge pending. A bit written as 0 leaves that group's pending unchanged.
- R8: When an edge is detected in the same cycle as an acknowledge of that group, pending stays set.
- R9: Offset 136 returns the raw pending bits in [7:0]. Offset 140 returns the raw pending bits ANDed with the enable register.
- R10: `irq_o` is the registered OR of the enabled pending bits. After a pin change that produces a pending bit, `irq_o` rises on the fourth rising clock edge: two synchroniser stages, one pending stage and one output stage.
- R11: A read returns data on the clock edge after the request. Reads of offsets other than 120, 124, 128, 136 and 140 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 128 | GPIO inputs, port p bit b at index 32*p+b |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the request |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two functions can fall in the same cycle: detecting a new edge and acknowledging the same group. The bench raises a pin in rising-edge mode and times the acknowledge write so that it reaches the register on the exact clock edge where the edge detector fires. It then expects the raw pending bit to stay set. A follow-up acknowledge one cycle clear of any edge must then clear it, which shows that the acknowledge path itself works.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    TRIG_OFF  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_SET  = 3'd3,
    TRIG_RSVD = 3'd4,
    TRIG_RISE = 3'd5,
    TRIG_FALL = 3'd6,
    TRIG_ANY  = 3'd7
  } trig_mode_e;

  localparam int OFF_MODE   = 120;
  localparam int OFF_SEL    = 124;
  localparam int OFF_ENABLE = 128;
  localparam int OFF_ACK    = 132;
  localparam int OFF_RAW    = 136;
  localparam int OFF_MASKED = 140;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NGRP   = 8,
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_en,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  input  logic [NGRP-1:0]        pend_i,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic [3*NGRP-1:0]      mode_o,
  output logic [SEL_W*NGRP-1:0]  sel_o,
  output logic [NGRP-1:0]        mask_o,
  output logic [NGRP-1:0]        ack_o
);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_SEL    = ADDR_W'(OFF_SEL);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFF_MASKED);

  logic                  wr_en, rd_en;
  logic [3*NGRP-1:0]     mode_q;
  logic [SEL_W*NGRP-1:0] sel_q;
  logic [NGRP-1:0]       mask_q;
  logic [DATA_W-1:0]     rdata_q, rdata_d;

  assign wr_en = bus_en & bus_we;
  assign rd_en = bus_en & ~bus_we;

  always_comb begin
    case (bus_addr)
      A_MODE:   rdata_d = DATA_W'(mode_q);
      A_SEL:    rdata_d = DATA_W'(sel_q);
      A_ENABLE: rdata_d = DATA_W'(mask_q);
      A_RAW:    rdata_d = DATA_W'(pend_i);
      A_MASKED: rdata_d = DATA_W'(pend_i & mask_q);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      sel_q   <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en) begin
        case (bus_addr)
          A_MODE:   mode_q <= bus_wdata[3*NGRP-1:0];
          A_SEL:    sel_q  <= bus_wdata[SEL_W*NGRP-1:0];
          A_ENABLE: mask_q <= bus_wdata[NGRP-1:0];
          default:  ;
        endcase
      end
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign ack_o     = (wr_en && bus_addr == A_ACK) ? bus_wdata[NGRP-1:0] : '0;
  assign mode_o    = mode_q;
  assign sel_o     = sel_q;
  assign mask_o    = mask_q;
  assign bus_rdata = rdata_q;

  // R11: unknown offsets read back as zero on the following cycle
  a_r11_undef_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr != A_MODE && bus_addr != A_SEL && bus_addr != A_ENABLE &&
     bus_addr != A_RAW && bus_addr != A_MASKED) |=> (bus_rdata == '0));

  // R2: a write to the enable register is visible on the next cycle
  a_r2_enable_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_addr == A_ENABLE) |=> (mask_o == $past(bus_wdata[NGRP-1:0])));
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 128,
  parameter int NGRP  = 8,
  parameter int SEL_W = 4,
  parameter int G     = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [2:0]       mode_i,
  input  logic             ack_i,
  output logic             pend_o
);
  localparam int IDX_W = $clog2(NPINS);

  logic [IDX_W-1:0] idx;
  logic tap, meta_q, sync_q, prev_q, pend_q, pend_d;
  logic rise, fall, edge_hit, edge_mode;

  // byte lane chosen by the selector, bit within the lane fixed by G
  assign idx = IDX_W'(sel_i) * IDX_W'(NGRP) + IDX_W'(G);
  assign tap = pins_i[idx];

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;

  always_comb begin
    edge_hit  = 1'b0;
    edge_mode = 1'b0;
    pend_d    = 1'b0;
    case (trig_mode_e'(mode_i))
      TRIG_HIGH: pend_d = sync_q;
      TRIG_LOW:  pend_d = ~sync_q;
      TRIG_SET:  pend_d = 1'b1;
      TRIG_RISE: begin edge_mode = 1'b1; edge_hit = rise;        end
      TRIG_FALL: begin edge_mode = 1'b1; edge_hit = fall;        end
      TRIG_ANY:  begin edge_mode = 1'b1; edge_hit = rise | fall; end
      default:   pend_d = 1'b0;
    endcase
    if (edge_mode) pend_d = edge_hit | (pend_q & ~ack_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      meta_q <= tap;
      sync_q <= meta_q;
      prev_q <= sync_q;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R8: a detected edge always leaves the group pending, acknowledge or not
  a_r8_edge_beats_ack: assert property (@(posedge clk) disable iff (rst)
    (edge_hit && ack_i) |=> pend_q);

  // R7: acknowledge without a fresh edge clears a latched edge
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && ack_i && !edge_hit) |=> !pend_q);

  // R5: forced and disabled modes
  a_r5_forced_set: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd3) |=> pend_q);
  a_r5_off_clear: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd0 || mode_i == 3'd4) |=> !pend_q);

  // R4: level-high follows the synchronised pin one cycle later
  a_r4_level_follows: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd1) |=> (pend_q == $past(sync_q)));
endmodule

// File: rtl/gpio_group_irq.sv
module gpio_group_irq
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int NGRP      = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS*PORT_W-1:0] pins_i,
  input  logic                        bus_en,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic                        irq_o
);
  localparam int NPINS = NUM_PORTS * PORT_W;
  localparam int SEL_W = $clog2(NPINS / NGRP);

  logic [3*NGRP-1:0]     mode_w;
  logic [SEL_W*NGRP-1:0] sel_w;
  logic [NGRP-1:0]       mask_w, ack_w, pend_w;
  logic                  irq_q;

  gpio_irq_regs #(
    .NGRP(NGRP), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pend_i(pend_w), .bus_rdata(bus_rdata),
    .mode_o(mode_w), .sel_o(sel_w), .mask_o(mask_w), .ack_o(ack_w)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    gpio_irq_group #(
      .NPINS(NPINS), .NGRP(NGRP), .SEL_W(SEL_W), .G(g)
    ) u_grp (
      .clk(clk), .rst(rst), .pins_i(pins_i),
      .sel_i(sel_w[SEL_W*g +: SEL_W]),
      .mode_i(mode_w[3*g +: 3]),
      .ack_i(ack_w[g]),
      .pend_o(pend_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend_w & mask_w);
  end

  assign irq_o = irq_q;

  // R10: output follows the enabled pending set with one register stage
  a_r10_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(pend_w & mask_w))));

  // R1: immediately after reset the line is quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !irq_o);
endmodule

// File: tb/test_gpio_group_irq.sv
module test_gpio_group_irq;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] pins = '0;
  logic         bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_group_irq i_gpio_group_irq (
    .clk(clk), .rst(rst), .pins_i(pins),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  localparam logic [7:0] MODE = 8'd120, SEL = 8'd124, ENA = 8'd128,
                         ACK = 8'd132, RAW = 8'd136, MSK = 8'd140;

  // {mode[3], sel[4], group[3], pin[7], level[1], expected pending[1]}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {3'd1, 4'd0,  3'd0, 7'd0,   1'b1, 1'b1},
    {3'd1, 4'd0,  3'd0, 7'd0,   1'b0, 1'b0},
    {3'd2, 4'd5,  3'd3, 7'd43,  1'b0, 1'b1},
    {3'd2, 4'd5,  3'd3, 7'd43,  1'b1, 1'b0},
    {3'd3, 4'd9,  3'd7, 7'd79,  1'b0, 1'b1},
    {3'd0, 4'd15, 3'd6, 7'd126, 1'b1, 1'b0},
    {3'd4, 4'd2,  3'd1, 7'd17,  1'b1, 1'b0},
    {3'd1, 4'd15, 3'd7, 7'd127, 1'b1, 1'b1},
    {3'd1, 4'd12, 3'd4, 7'd100, 1'b1, 1'b1},
    {3'd1, 4'd12, 3'd4, 7'd100, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    rd(MODE, d); check("R1 mode", d, 32'd0);
    rd(SEL, d);  check("R1 sel", d, 32'd0);
    rd(ENA, d);  check("R1 enable", d, 32'd0);
    rd(RAW, d);  check("R1 raw", d, 32'd0);

    // R3 R4 R5 selection and level/forced modes
    for (int i = 0; i < NV; i++) begin
      logic [2:0] m; logic [3:0] s; logic [2:0] g; logic [6:0] p; logic v, e;
      {m, s, g, p, v, e} = VEC[i];
      pins = v ? (128'd1 << p) : ~(128'd1 << p);
      wr(MODE, 32'(m) << (3 * g));
      wr(SEL, 32'(s) << (4 * g));
      wr(ENA, 32'hFF);
      settle();
      rd(RAW, d);
      check($sformatf("R3 R4 R5 vec%0d raw", i), d, 32'(e) << g);
      check($sformatf("R10 vec%0d irq", i), {31'd0, irq_o}, {31'd0, e});
    end

    // R6 rising edge on group 2, selector 0 -> pin 2
    pins = '0;
    wr(ENA, 32'h0); wr(SEL, 32'h0); wr(MODE, 32'd5 << 6);
    settle();
    wr(ACK, 32'hFF);
    rd(RAW, d); check("R7 cleared start", d, 32'd0);
    pins[2] = 1'b1; settle();
    rd(RAW, d); check("R6 rise latched", d, 32'h4);
    rd(MSK, d); check("R9 masked off", d, 32'h0);
    check("R10 irq masked", {31'd0, irq_o}, 32'd0);
    pins[2] = 1'b0; settle();
    rd(RAW, d); check("R6 stays after fall", d, 32'h4);
    wr(ENA, 32'h4); settle();
    rd(MSK, d); check("R9 masked on", d, 32'h4);
    check("R10 irq on", {31'd0, irq_o}, 32'd1);
    wr(ACK, 32'h0);
    rd(RAW, d); check("R7 ack zero ignored", d, 32'h4);
    wr(ACK, 32'h4); @(negedge clk);
    rd(RAW, d); check("R7 ack clears", d, 32'h0);
    check("R10 irq drops", {31'd0, irq_o}, 32'd0);

    // R6 falling mode
    wr(MODE, 32'd6 << 6);
    pins[2] = 1'b1; settle();
    rd(RAW, d); check("R6 fall ignores rise", d, 32'h0);
    pins[2] = 1'b0; settle();
    rd(RAW, d); check("R6 fall latched", d, 32'h4);
    wr(ACK, 32'h4);

    // R6 R10 either edge, with latency
    wr(MODE, 32'd7 << 6); settle();
    wr(ACK, 32'h4);
    pins[2] = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 irq not yet", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    check("R10 irq fourth edge", {31'd0, irq_o}, 32'd1);
    wr(ACK, 32'h4);
    pins[2] = 1'b0; settle();
    rd(RAW, d); check("R6 any fall", d, 32'h4);
    wr(ACK, 32'h4);

    // R8 edge and acknowledge in the same cycle
    wr(MODE, 32'd5 << 6); settle();
    wr(ACK, 32'h4);
    pins[2] = 1'b1;
    repeat (2) @(negedge clk);
    wr(ACK, 32'h4);
    settle();
    rd(RAW, d); check("R8 edge wins", d, 32'h4);
    wr(ACK, 32'h4);
    rd(RAW, d); check("R8 later ack clears", d, 32'h0);

    // R4 acknowledge has no effect on a level mode
    wr(MODE, 32'd1 << 6); settle();
    wr(ACK, 32'hFF);
    rd(RAW, d); check("R4 level ignores ack", d, 32'h4);

    // R2 readback layout, R11 undefined offsets
    wr(MODE, 32'hFFFF_FFFF); rd(MODE, d); check("R2 mode", d, 32'h00FF_FFFF);
    wr(SEL, 32'hA5A5_5A5A);  rd(SEL, d);  check("R2 sel", d, 32'hA5A5_5A5A);
    wr(ENA, 32'hFFFF_FF33);  rd(ENA, d);  check("R2 enable", d, 32'h33);
    rd(8'd0, d);   check("R11 offset 0", d, 32'h0);
    rd(8'd116, d); check("R11 offset 116", d, 32'h0);
    rd(ACK, d);    check("R11 ack reads zero", d, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule